// File: doc/BRIEF.md
# Doorbell Message Register Mailbox

This block passes short messages one way between two processors that share a register space. The sending processor fills a bank of 32-bit message words, then rings a doorbell by writing a trigger register. The receiving processor is interrupted, reads the words back, and answers by writing an acknowledge bit into the same trigger register. That acknowledge interrupts the sender. The first message word carries the message length in bytes, and the block presents the matching word count directly.

Each processor has its own register port: a write strobe, a read strobe, a byte address and write data, plus a read-data register of its own. Both ports see the same map. One status word holds the two pending events. Each event is set by a trigger write and cleared by writing a one to the matching bit of a clear register. Every side has its own enable mask over that status word, and drives a level interrupt while any enabled status bit is set. Which event reaches which side therefore depends only on how software programs the two masks.

Top module: `mbx_top`

## Requirements
- R1: Message words live at byte offsets 0x00, 0x04 and so on up to 0x7C (word index = address bits 6:2). Either port can write or read them. They reset to zero and keep their value until they are written again.
- R2: When both ports write the same message word in the same cycle, the sender port's data is stored.
- R3: A write to the trigger register at 0x80 sets status bit 0 (doorbell) from data bit 0, and sets status bit 1 (acknowledge) from data bit 1. Reading 0x80 returns zero.
- R4: Status reads at 0xC8 in bits 1:0, with all higher bits zero. Writing a one to a bit at 0xC4 clears that status bit. Zero bits leave their status bits unchanged, and status does not change without a trigger or clear write.
- R5: If a bit is set and cleared in the same cycle, from either port, the set wins and the bit stays at one.
- R6: The sender enable mask is at 0xBC and the receiver enable mask is at 0xC0. Each mask is 2 bits, reads back in bits 1:0 and resets to zero. If both ports write the same mask in one cycle, the sender port wins.
- R7: irq_snd is high exactly when status AND sender mask is non-zero, and irq_rcv follows the same rule with the receiver mask. Both are visible in the cycle after the register update, and each holds until status or its mask changes.
- R8: msg_words equals the low 7 bits of message word 0 divided by 4, rounded up. For example, 0x45 gives 18, 0x7F gives 32, 0x80 gives 0 and 0x05 gives 2.
- R9: A read strobe loads that port's read data on the next clock edge, using register values from before any write in the same cycle. Unmapped offsets read zero, and read data holds while the port issues no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| snd_wr_en | input | 1 | Sender port write strobe |
| snd_rd_en | input | 1 | Sender port read strobe |
| snd_addr | input | 8 | Sender port byte address |
| snd_wdata | input | 32 | Sender port write data |
| snd_rdata | output | 32 | Sender port read data register |
| rcv_wr_en | input | 1 | Receiver port write strobe |
| rcv_rd_en | input | 1 | Receiver port read strobe |
| rcv_addr | input | 8 | Receiver port byte address |
| rcv_wdata | input | 32 | Receiver port write data |
| rcv_rdata | output | 32 | Receiver port read data register |
| irq_snd | output | 1 | Sender-side level interrupt |
| irq_rcv | output | 1 | Receiver-side level interrupt |
| msg_words | output | 6 | Word count decoded from message word 0 |

## Verification
Several properties are checked on every cycle:
- each trigger bit appears in status one cycle later;
- a clear removes a bit only when no set targets it;
- status stays still without trigger or clear traffic;
- an interrupt is never high without a status bit behind it;
- the trigger register always reads zero;
- the word count never exceeds 32.

Port priority on shared message words, the exact routing of doorbell and acknowledge through the two masks, and the rounding of the length field can only be shown by the bench's scenarios. These include a full doorbell/acknowledge handshake, a set and clear colliding in one cycle, and a randomized run checked cycle by cycle against a behavioural model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int EVT_W = 2;
  localparam int LEN_W = 7;
  localparam int WC_W  = 6;
  localparam int WA_W  = AW - 2;

  // word offsets (byte offset / 4)
  localparam logic [WA_W-1:0] WA_TRIG   = 6'h20; // 0x80
  localparam logic [WA_W-1:0] WA_EN_SND = 6'h2F; // 0xBC
  localparam logic [WA_W-1:0] WA_EN_RCV = 6'h30; // 0xC0
  localparam logic [WA_W-1:0] WA_CLR    = 6'h31; // 0xC4
  localparam logic [WA_W-1:0] WA_STAT   = 6'h32; // 0xC8

  localparam int EVT_DB  = 0;
  localparam int EVT_ACK = 1;

  typedef struct packed {
    logic [EVT_W-1:0] set;
    logic [EVT_W-1:0] clr;
    logic             en_snd_we;
    logic             en_rcv_we;
  } ctl_strb_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int NUM_MSG = 32
) (
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NUM_MSG-1:0] msg_we,
  output ctl_strb_t          strb,
  output logic [EVT_W-1:0]   evt_data
);
  logic [WA_W-1:0] wa;
  logic            unused_bits;

  assign wa          = addr[AW-1:2];
  assign evt_data    = wdata[EVT_W-1:0];
  assign unused_bits = ^{addr[1:0], wdata[DW-1:EVT_W]};

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_we
    assign msg_we[i] = wr_en && (wa == WA_W'(i));
  end

  always_comb begin
    strb = '0;
    if (wr_en) begin
      case (wa)
        WA_TRIG:   strb.set       = wdata[EVT_W-1:0];
        WA_CLR:    strb.clr       = wdata[EVT_W-1:0];
        WA_EN_SND: strb.en_snd_we = 1'b1;
        WA_EN_RCV: strb.en_rcv_we = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank
  import mbx_pkg::*;
#(
  parameter int NUM_MSG = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_MSG-1:0]          snd_we,
  input  logic [DW-1:0]               snd_wdata,
  input  logic [NUM_MSG-1:0]          rcv_we,
  input  logic [DW-1:0]               rcv_wdata,
  output logic [NUM_MSG-1:0][DW-1:0]  words,
  output logic [WC_W-1:0]             msg_words
);
  for (genvar i = 0; i < NUM_MSG; i++) begin : g_word
    logic [DW-1:0] word_d;
    logic [DW-1:0] word_q;
    logic          word_en;

    always_comb begin
      word_en = snd_we[i] || rcv_we[i];
      word_d  = snd_we[i] ? snd_wdata : rcv_wdata; // sender port wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign words[i] = word_q;
  end

  logic [LEN_W:0] len_rnd;
  logic           unused_lsb;

  assign len_rnd    = {1'b0, words[0][LEN_W-1:0]} + (LEN_W+1)'(3);
  assign msg_words  = len_rnd[LEN_W:2];
  assign unused_lsb = ^len_rnd[1:0];
endmodule

// File: rtl/mbx_evt_ctrl.sv
module mbx_evt_ctrl
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_strb_t        snd_strb,
  input  logic [EVT_W-1:0] snd_data,
  input  ctl_strb_t        rcv_strb,
  input  logic [EVT_W-1:0] rcv_data,
  output logic [EVT_W-1:0] stat_q,
  output logic [EVT_W-1:0] en_snd_q,
  output logic [EVT_W-1:0] en_rcv_q,
  output logic             irq_snd,
  output logic             irq_rcv
);
  logic [EVT_W-1:0] set_v, clr_v, stat_d, en_snd_d, en_rcv_d;
  logic             stat_en, en_snd_en, en_rcv_en;

  always_comb begin
    set_v     = snd_strb.set | rcv_strb.set;
    clr_v     = snd_strb.clr | rcv_strb.clr;
    stat_en   = |{set_v, clr_v};
    stat_d    = (stat_q & ~clr_v) | set_v; // set has priority
    en_snd_en = snd_strb.en_snd_we || rcv_strb.en_snd_we;
    en_snd_d  = snd_strb.en_snd_we ? snd_data : rcv_data;
    en_rcv_en = snd_strb.en_rcv_we || rcv_strb.en_rcv_we;
    en_rcv_d  = snd_strb.en_rcv_we ? snd_data : rcv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      en_snd_q <= '0;
      en_rcv_q <= '0;
    end else begin
      if (stat_en)   stat_q   <= stat_d;
      if (en_snd_en) en_snd_q <= en_snd_d;
      if (en_rcv_en) en_rcv_q <= en_rcv_d;
    end
  end

  assign irq_snd = |(stat_q & en_snd_q);
  assign irq_rcv = |(stat_q & en_rcv_q);
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int NUM_MSG = 32 // 2..32, bank must stay below the trigger offset
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snd_wr_en,
  input  logic            snd_rd_en,
  input  logic [AW-1:0]   snd_addr,
  input  logic [DW-1:0]   snd_wdata,
  output logic [DW-1:0]   snd_rdata,
  input  logic            rcv_wr_en,
  input  logic            rcv_rd_en,
  input  logic [AW-1:0]   rcv_addr,
  input  logic [DW-1:0]   rcv_wdata,
  output logic [DW-1:0]   rcv_rdata,
  output logic            irq_snd,
  output logic            irq_rcv,
  output logic [WC_W-1:0] msg_words
);
  localparam int NP    = 2;
  localparam int IDX_W = $clog2(NUM_MSG);

  logic                       p_wr   [NP];
  logic                       p_rd   [NP];
  logic [AW-1:0]              p_addr [NP];
  logic [DW-1:0]              p_wdat [NP];
  logic [DW-1:0]              p_rdat [NP];
  logic [NUM_MSG-1:0]         p_we   [NP];
  ctl_strb_t                  p_strb [NP];
  logic [EVT_W-1:0]           p_evt  [NP];

  logic [NUM_MSG-1:0][DW-1:0] words;
  logic [EVT_W-1:0]           stat_q, en_snd_q, en_rcv_q;

  assign p_wr[0] = snd_wr_en;  assign p_wr[1] = rcv_wr_en;
  assign p_rd[0] = snd_rd_en;  assign p_rd[1] = rcv_rd_en;
  assign p_addr[0] = snd_addr; assign p_addr[1] = rcv_addr;
  assign p_wdat[0] = snd_wdata; assign p_wdat[1] = rcv_wdata;
  assign snd_rdata = p_rdat[0];
  assign rcv_rdata = p_rdat[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [WA_W-1:0] wa;
    logic [DW-1:0]   rd_d;
    logic [DW-1:0]   rd_q;

    mbx_port_decode #(.NUM_MSG(NUM_MSG)) u_dec (
      .wr_en    (p_wr[p]),
      .addr     (p_addr[p]),
      .wdata    (p_wdat[p]),
      .msg_we   (p_we[p]),
      .strb     (p_strb[p]),
      .evt_data (p_evt[p])
    );

    assign wa = p_addr[p][AW-1:2];

    always_comb begin
      rd_d = '0;
      if (int'(wa) < NUM_MSG) begin
        rd_d = words[wa[IDX_W-1:0]];
      end else begin
        case (wa)
          WA_STAT:   rd_d[EVT_W-1:0] = stat_q;
          WA_EN_SND: rd_d[EVT_W-1:0] = en_snd_q;
          WA_EN_RCV: rd_d[EVT_W-1:0] = en_rcv_q;
          default:   ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (p_rd[p]) rd_q <= rd_d;
    end

    assign p_rdat[p] = rd_q;
  end

  mbx_msg_bank #(.NUM_MSG(NUM_MSG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .snd_we    (p_we[0]),
    .snd_wdata (snd_wdata),
    .rcv_we    (p_we[1]),
    .rcv_wdata (rcv_wdata),
    .words     (words),
    .msg_words (msg_words)
  );

  mbx_evt_ctrl u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .snd_strb (p_strb[0]),
    .snd_data (p_evt[0]),
    .rcv_strb (p_strb[1]),
    .rcv_data (p_evt[1]),
    .stat_q   (stat_q),
    .en_snd_q (en_snd_q),
    .en_rcv_q (en_rcv_q),
    .irq_snd  (irq_snd),
    .irq_rcv  (irq_rcv)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             snd_wr_en,
  input logic             snd_rd_en,
  input logic [AW-1:0]    snd_addr,
  input logic [DW-1:0]    snd_wdata,
  input logic [DW-1:0]    snd_rdata,
  input logic             rcv_wr_en,
  input logic [AW-1:0]    rcv_addr,
  input logic [DW-1:0]    rcv_wdata,
  input logic [EVT_W-1:0] stat,
  input logic             irq_snd,
  input logic             irq_rcv,
  input logic [WC_W-1:0]  msg_words
);
  logic [EVT_W-1:0] c_set, c_clr;
  logic             c_en_snd_wr;
  logic             unused_chk;

  assign unused_chk = ^{snd_addr[1:0], rcv_addr[1:0],
                        snd_wdata[DW-1:EVT_W], rcv_wdata[DW-1:EVT_W]};

  always_comb begin
    c_set = '0;
    c_clr = '0;
    if (snd_wr_en && snd_addr[AW-1:2] == WA_TRIG) c_set |= snd_wdata[EVT_W-1:0];
    if (rcv_wr_en && rcv_addr[AW-1:2] == WA_TRIG) c_set |= rcv_wdata[EVT_W-1:0];
    if (snd_wr_en && snd_addr[AW-1:2] == WA_CLR)  c_clr |= snd_wdata[EVT_W-1:0];
    if (rcv_wr_en && rcv_addr[AW-1:2] == WA_CLR)  c_clr |= rcv_wdata[EVT_W-1:0];
    c_en_snd_wr = (snd_wr_en && snd_addr[AW-1:2] == WA_EN_SND) ||
                  (rcv_wr_en && rcv_addr[AW-1:2] == WA_EN_SND);
  end

  p_set_db_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_set[EVT_DB] |=> stat[EVT_DB]);

  p_set_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_set[EVT_ACK] |=> stat[EVT_ACK]);

  p_trig_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_rd_en && snd_addr[AW-1:2] == WA_TRIG) |=> (snd_rdata == '0));

  p_clear_db_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr[EVT_DB] && !c_set[EVT_DB]) |=> !stat[EVT_DB]);

  p_stat_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_set == '0 && c_clr == '0) |=> $stable(stat));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_set & c_clr) != '0) |=> ((stat & $past(c_set & c_clr)) == $past(c_set & c_clr)));

  p_irq_needs_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_snd || irq_rcv) |-> (stat != '0));

  p_irq_snd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_snd && c_clr == '0 && !c_en_snd_wr) |=> irq_snd);

  p_words_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_words <= WC_W'(32));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_rd_en |=> $stable(snd_rdata));
endmodule

bind mbx_top mbx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .snd_wr_en (snd_wr_en),
  .snd_rd_en (snd_rd_en),
  .snd_addr  (snd_addr),
  .snd_wdata (snd_wdata),
  .snd_rdata (snd_rdata),
  .rcv_wr_en (rcv_wr_en),
  .rcv_addr  (rcv_addr),
  .rcv_wdata (rcv_wdata),
  .stat      (stat_q),
  .irq_snd   (irq_snd),
  .irq_rcv   (irq_rcv),
  .msg_words (msg_words)
);

// File: tb/tb_mbx_top.sv
module tb_mbx_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        snd_wr_en, snd_rd_en, rcv_wr_en, rcv_rd_en;
  logic [7:0]  snd_addr, rcv_addr;
  logic [31:0] snd_wdata, rcv_wdata;
  logic [31:0] snd_rdata, rcv_rdata;
  logic        irq_snd, irq_rcv;
  logic [5:0]  msg_words;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk; // 50 MHz

  mbx_top dut (
    .clk(clk), .rst_n(rst_n),
    .snd_wr_en(snd_wr_en), .snd_rd_en(snd_rd_en), .snd_addr(snd_addr),
    .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
    .rcv_wr_en(rcv_wr_en), .rcv_rd_en(rcv_rd_en), .rcv_addr(rcv_addr),
    .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
    .irq_snd(irq_snd), .irq_rcv(irq_rcv), .msg_words(msg_words)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_msg [32];
  logic [1:0]  m_stat, m_en_s, m_en_r;
  logic [31:0] m_rd_s, m_rd_r;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w < 32) return m_msg[w];
    case (w)
      'h32: return {30'd0, m_stat};
      'h2F: return {30'd0, m_en_s};
      'h30: return {30'd0, m_en_r};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int m_words();
    return (int'(m_msg[0][6:0]) + 3) / 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_msg[i]) m_msg[i] = 32'd0;
      m_stat = 2'b00; m_en_s = 2'b00; m_en_r = 2'b00;
      m_rd_s = 32'd0; m_rd_r = 32'd0;
    end else begin
      logic [31:0] rs, rr;
      logic [1:0]  setv, clrv;
      rs = m_read(snd_addr);
      rr = m_read(rcv_addr);
      setv = 2'b00; clrv = 2'b00;
      if (rcv_wr_en) begin
        if (rcv_addr[7:2] < 6'd32) m_msg[rcv_addr[6:2]] = rcv_wdata;
        if (rcv_addr[7:2] == 6'h20) setv |= rcv_wdata[1:0];
        if (rcv_addr[7:2] == 6'h31) clrv |= rcv_wdata[1:0];
        if (rcv_addr[7:2] == 6'h2F) m_en_s = rcv_wdata[1:0];
        if (rcv_addr[7:2] == 6'h30) m_en_r = rcv_wdata[1:0];
      end
      if (snd_wr_en) begin
        if (snd_addr[7:2] < 6'd32) m_msg[snd_addr[6:2]] = snd_wdata;
        if (snd_addr[7:2] == 6'h20) setv |= snd_wdata[1:0];
        if (snd_addr[7:2] == 6'h31) clrv |= snd_wdata[1:0];
        if (snd_addr[7:2] == 6'h2F) m_en_s = snd_wdata[1:0];
        if (snd_addr[7:2] == 6'h30) m_en_r = snd_wdata[1:0];
      end
      m_stat = (m_stat & ~clrv) | setv;
      if (snd_rd_en) m_rd_s = rs;
      if (rcv_rd_en) m_rd_r = rr;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9", "snd_rdata model", snd_rdata, m_rd_s);
      chk("R9", "rcv_rdata model", rcv_rdata, m_rd_r);
      chk("R7", "irq_snd model", {31'd0, irq_snd}, {31'd0, |(m_stat & m_en_s)});
      chk("R7", "irq_rcv model", {31'd0, irq_rcv}, {31'd0, |(m_stat & m_en_r)});
      chk("R8", "msg_words model", {26'd0, msg_words}, 32'(m_words()));
    end
  end

  // one bus cycle on both ports; returns at the negedge where results show
  task automatic op(input logic sw, input logic sr, input logic [7:0] sa, input logic [31:0] sd,
                    input logic rw, input logic rr, input logic [7:0] ra, input logic [31:0] rd);
    snd_wr_en = sw; snd_rd_en = sr; snd_addr = sa; snd_wdata = sd;
    rcv_wr_en = rw; rcv_rd_en = rr; rcv_addr = ra; rcv_wdata = rd;
    @(negedge clk);
    snd_wr_en = 1'b0; snd_rd_en = 1'b0; rcv_wr_en = 1'b0; rcv_rd_en = 1'b0;
  endtask

  task automatic swr(input logic [7:0] a, input logic [31:0] d); op(1, 0, a, d, 0, 0, 8'h0, 0); endtask
  task automatic rwr(input logic [7:0] a, input logic [31:0] d); op(0, 0, 8'h0, 0, 1, 0, a, d); endtask
  task automatic srd(input logic [7:0] a); op(0, 1, a, 0, 0, 0, 8'h0, 0); endtask
  task automatic rrd(input logic [7:0] a); op(0, 0, 8'h0, 0, 0, 1, a, 0); endtask

  function automatic logic [7:0] pick_addr(input int sel);
    case (sel % 8)
      0, 1, 2: return {1'b0, 5'($urandom), 2'b00};
      3: return 8'h80;
      4: return 8'hBC;
      5: return 8'hC0;
      6: return 8'hC4;
      default: return ($urandom % 2) ? 8'hC8 : 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    snd_wr_en = 0; snd_rd_en = 0; snd_addr = 0; snd_wdata = 0;
    rcv_wr_en = 0; rcv_rd_en = 0; rcv_addr = 0; rcv_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R7", "irq_snd reset", {31'd0, irq_snd}, 32'd0);
    chk("R7", "irq_rcv reset", {31'd0, irq_rcv}, 32'd0);
    srd(8'h40);
    chk("R1", "msg word reset", snd_rdata, 32'd0);
    rrd(8'hBC);
    chk("R6", "sender mask reset", rcv_rdata, 32'd0);

    // length field and word count
    swr(8'h00, 32'hABCD_0045);
    chk("R8", "words for 69 bytes", {26'd0, msg_words}, 32'd18);
    rwr(8'h00, 32'h0000_007F);
    chk("R8", "words for 127 bytes", {26'd0, msg_words}, 32'd32);
    swr(8'h00, 32'h0000_0080);
    chk("R8", "length bits zero", {26'd0, msg_words}, 32'd0);
    swr(8'h00, 32'h0000_0005);
    chk("R8", "words for 5 bytes", {26'd0, msg_words}, 32'd2);

    // message bank
    rwr(8'h7C, 32'hDEAD_BEEF);
    swr(8'h20, 32'h1234_5678);
    rrd(8'h7C);
    chk("R1", "top word readback", rcv_rdata, 32'hDEAD_BEEF);
    srd(8'h20);
    chk("R1", "mid word readback", snd_rdata, 32'h1234_5678);
    op(1, 0, 8'h10, 32'h1111_1111, 1, 0, 8'h10, 32'h2222_2222);
    rrd(8'h10);
    chk("R2", "same-word write priority", rcv_rdata, 32'h1111_1111);
    op(0, 1, 8'h10, 0, 1, 0, 8'h10, 32'h3333_3333);
    chk("R9", "read sees pre-write value", snd_rdata, 32'h1111_1111);
    srd(8'hD0);
    chk("R9", "unmapped reads zero", snd_rdata, 32'd0);
    repeat (2) @(negedge clk);
    chk("R9", "read data held", snd_rdata, 32'd0);

    // masks
    rwr(8'hC0, 32'h0000_0001);
    swr(8'hBC, 32'hFFFF_FFFE);
    rrd(8'hC0);
    chk("R6", "receiver mask readback", rcv_rdata, 32'd1);
    srd(8'hBC);
    chk("R6", "sender mask readback", snd_rdata, 32'd2);

    // doorbell / acknowledge handshake
    srd(8'h80);
    chk("R3", "trigger reads zero", snd_rdata, 32'd0);
    swr(8'h80, 32'h0000_0001);
    chk("R3", "doorbell raises irq_rcv", {31'd0, irq_rcv}, 32'd1);
    chk("R7", "doorbell masked for sender", {31'd0, irq_snd}, 32'd0);
    rrd(8'hC8);
    chk("R4", "status after doorbell", rcv_rdata, 32'd1);
    rwr(8'hC4, 32'h0000_0002);
    chk("R4", "clear of other bit keeps doorbell", {31'd0, irq_rcv}, 32'd1);
    rwr(8'hC4, 32'h0000_0001);
    chk("R4", "doorbell cleared", {31'd0, irq_rcv}, 32'd0);
    rwr(8'h80, 32'h0000_0002);
    chk("R7", "ack raises irq_snd", {31'd0, irq_snd}, 32'd1);
    chk("R7", "ack masked for receiver", {31'd0, irq_rcv}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R7", "irq_snd level holds", {31'd0, irq_snd}, 32'd1);

    // set and clear in the same cycle
    op(1, 0, 8'hC4, 32'h2, 1, 0, 8'h80, 32'h2);
    chk("R5", "set beats clear", {31'd0, irq_snd}, 32'd1);
    swr(8'hC4, 32'h0000_0002);
    chk("R4", "ack cleared", {31'd0, irq_snd}, 32'd0);

    // masked event still visible in status
    rwr(8'hC0, 32'h0);
    swr(8'h80, 32'h1);
    chk("R7", "masked doorbell no irq", {31'd0, irq_rcv}, 32'd0);
    srd(8'hC8);
    chk("R4", "masked doorbell in status", snd_rdata, 32'd1);

    // randomized traffic, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      op(1'($urandom), 1'($urandom), pick_addr(int'($urandom % 64)), $urandom,
         1'($urandom), 1'($urandom), pick_addr(int'($urandom % 64)), $urandom);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule